// File: doc/BRIEF.md
# Byte-Laned Asynchronous SRAM Interface

This block is a synthesizable model of a static RAM word array that sits behind a 16-bit bidirectional data bus split into two 8-bit lanes. A pair of chip selects with opposite polarity, a write strobe, an output enable and one active-low enable per lane decide what happens on each cycle. Depending on these inputs, the block stores the enabled bytes of the bus into the addressed word, drives the enabled bytes of the addressed word onto the bus, or leaves the bus floating. It also raises a standby flag whenever the array is idle because it is deselected or both lanes are disabled.

Reads are combinational from the current address and controls. Writes are committed on the rising edge of `clk_i` in every cycle in which the write conditions hold. The depth is set by `ADDR_W`: the bench uses the default of 10 bits, and a full-size array of 2M words uses `ADDR_W = 21`. Internally the bus is kept as separate data-in, data-out and per-lane drive-enable signals, and it is resolved to tri-state only in the top module.

Top module: `byte_lane_sram`

## Requirements
- R1: The device is selected only when `sel_n_i` is 0 and `sel_i` is 1. With any other combination, no lane is driven and no write takes place.
- R2: A write takes place when the device is selected and `wr_n_i` is 0. It is stored at the rising edge of `clk_i`, and `oe_n_i` has no effect on it.
- R3: In a write, `lane_n_i[0]` = 0 stores bus bits 7:0 and `lane_n_i[1]` = 0 stores bus bits 15:8. A lane whose enable is 1 keeps its previous content.
- R4: A read occurs when the device is selected, `oe_n_i` is 0 and `wr_n_i` is 1. Lane i of `data_io` then carries the stored byte i if `lane_n_i[i]` is 0, and is high-impedance otherwise.
- R5: Both lanes of `data_io` are high-impedance when `oe_n_i` is 1, when both lane enables are 1, or during a write.
- R6: `standby_o` is 1 exactly when `sel_n_i` is 1, `sel_i` is 0, or both lane enables are 1.
- R7: While `rst_ni` is low, every word is cleared, so any address reads 0 after reset.
- R8: Each address holds its own word. A write to one address, including the lowest and the highest address, leaves every other address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write commit clock |
| rst_ni | input | 1 | Active-low asynchronous reset, clears the array |
| addr_i | input | ADDR_W | Word address |
| sel_n_i | input | 1 | Active-low chip select |
| sel_i | input | 1 | Active-high chip select |
| wr_n_i | input | 1 | Active-low write strobe |
| oe_n_i | input | 1 | Active-low output enable |
| lane_n_i | input | 2 | Active-low lane enables, bit 0 for bits 7:0 and bit 1 for bits 15:8 |
| data_io | inout | 16 | Bidirectional data bus |
| standby_o | output | 1 | Idle indication |

## Verification
The bench applies all 64 combinations of the two selects, write strobe, output enable and two lane enables to one word that holds a different non-zero byte in each lane. For each combination it checks which lanes are driven, which float, and the standby flag. This separates a read-enable decode that is wrong in a single term from one that is right. During this sweep, the bench drives its own known value on every lane it expects to be floating, so a lane that the design drives by mistake shows up as a changed value. Masked writes with a single lane, both lanes, and no lane, followed by a read back of each lane alone, show whether the two lanes are stored independently. Writes attempted while deselected, a write with the output enable asserted, and writes to the lowest and highest addresses cover the select, override and addressing rules.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int unsigned LANES_DEF  = 2;
  localparam int unsigned LANE_W_DEF = 8;

  typedef struct packed {
    logic sel_n;
    logic sel;
    logic wr_n;
    logic oe_n;
  } sram_ctrl_t;
endpackage

// File: rtl/sram_ctrl_decode.sv
module sram_ctrl_decode
  import sram_pkg::*;
#(
  parameter int unsigned NUM_LANES = LANES_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  sram_ctrl_t           ctrl_i,
  input  logic [NUM_LANES-1:0] lane_n_i,
  output logic [NUM_LANES-1:0] wr_mask_o,
  output logic [NUM_LANES-1:0] drv_en_o,
  output logic                 standby_o
);
  logic selected, wr_act, rd_act;

  always_comb begin
    selected  = ~ctrl_i.sel_n & ctrl_i.sel;
    wr_act    = selected & ~ctrl_i.wr_n;
    rd_act    = selected & ~ctrl_i.oe_n & ctrl_i.wr_n;
    wr_mask_o = wr_act ? ~lane_n_i : '0;
    drv_en_o  = rd_act ? ~lane_n_i : '0;
    standby_o = ~selected | (&lane_n_i);
  end

  // R5: a write never coincides with a driven lane
  assert_write_hides_bus_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_mask_o != '0) |-> (drv_en_o == '0));

  // R2: output enable does not gate a write
  assert_oe_ignored_on_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.sel_n && ctrl_i.sel && !ctrl_i.wr_n) |-> (wr_mask_o == ~lane_n_i));
endmodule

// File: rtl/sram_word_array.sv
module sram_word_array
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned NUM_LANES = LANES_DEF,
  parameter int unsigned LANE_W    = LANE_W_DEF,
  localparam int unsigned DEPTH    = 1 << ADDR_W,
  localparam int unsigned DATA_W   = NUM_LANES * LANE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_LANES-1:0] wr_mask_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  output logic [DATA_W-1:0]    rd_data_o
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < int'(DEPTH); i++) lane_mem[i] <= '0;
      end else if (wr_mask_i[g]) begin
        lane_mem[addr_i] <= wr_data_i[g*LANE_W +: LANE_W];
      end
    end

    assign rd_data_o[g*LANE_W +: LANE_W] = lane_mem[addr_i];

    // R3: an enabled lane takes the bus byte
    assert_lane_store_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i == $past(addr_i) && $past(wr_mask_i[g]))
        |-> (rd_data_o[g*LANE_W +: LANE_W] == $past(wr_data_i[g*LANE_W +: LANE_W])));

    // R3: a disabled lane keeps its byte
    assert_lane_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i == $past(addr_i) && !$past(wr_mask_i[g]))
        |-> $stable(rd_data_o[g*LANE_W +: LANE_W]));
  end
endmodule

// File: rtl/byte_lane_sram.sv
module byte_lane_sram
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned NUM_LANES = LANES_DEF,
  parameter int unsigned LANE_W    = LANE_W_DEF,
  localparam int unsigned DATA_W   = NUM_LANES * LANE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 sel_n_i,
  input  logic                 sel_i,
  input  logic                 wr_n_i,
  input  logic                 oe_n_i,
  input  logic [NUM_LANES-1:0] lane_n_i,
  inout  wire  [DATA_W-1:0]    data_io,
  output logic                 standby_o
);
  sram_ctrl_t           ctrl;
  logic [NUM_LANES-1:0] wr_mask, drv_en;
  logic [DATA_W-1:0]    rd_data;

  assign ctrl = '{sel_n: sel_n_i, sel: sel_i, wr_n: wr_n_i, oe_n: oe_n_i};

  sram_ctrl_decode #(.NUM_LANES(NUM_LANES)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_i    (ctrl),
    .lane_n_i  (lane_n_i),
    .wr_mask_o (wr_mask),
    .drv_en_o  (drv_en),
    .standby_o (standby_o)
  );

  sram_word_array #(.ADDR_W(ADDR_W), .NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_mask_i (wr_mask),
    .wr_data_i (data_io),
    .rd_data_o (rd_data)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_bus
    assign data_io[g*LANE_W +: LANE_W] = drv_en[g] ? rd_data[g*LANE_W +: LANE_W] : 'z;
  end

  // R1: deselected means no drive and no write
  assert_deselect_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_n_i || !sel_i) |-> (drv_en == '0 && wr_mask == '0));

  // R6: a driven lane implies the device is active
  assert_drive_not_standby_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_en != '0) |-> !standby_o);

  // R4: only lanes with a low enable drive
  assert_drive_subset_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((drv_en & lane_n_i) == '0));
endmodule

// File: tb/byte_lane_sram_test.sv
module byte_lane_sram_test;
  localparam int AW = 10;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic          sel_n = 1, sel = 0, wr_n = 1, oe_n = 1;
  logic [1:0]    lane_n = 2'b11;
  logic          standby;
  wire  [15:0]   bus;
  logic [1:0]    tb_en = 2'b00;
  logic [15:0]   tb_val = '0;

  int n_run = 0, n_fail = 0;

  assign bus[7:0]  = tb_en[0] ? tb_val[7:0]  : 8'hzz;
  assign bus[15:8] = tb_en[1] ? tb_val[15:8] : 8'hzz;

  always #2 clk = ~clk;

  byte_lane_sram #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .sel_n_i(sel_n), .sel_i(sel),
    .wr_n_i(wr_n), .oe_n_i(oe_n), .lane_n_i(lane_n), .data_io(bus), .standby_o(standby)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    sel_n = 1; sel = 0; wr_n = 1; oe_n = 1; lane_n = 2'b11; tb_en = 2'b00;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [15:0] d, logic [1:0] ln,
                    logic sn = 0, logic s = 1, logic oe = 1);
    @(negedge clk);
    addr = a; sel_n = sn; sel = s; wr_n = 0; oe_n = oe; lane_n = ln;
    tb_val = d; tb_en = 2'b11;
    @(posedge clk);
    idle();
  endtask

  task automatic rd(string req, logic [AW-1:0] a, logic [1:0] ln, logic [15:0] exp);
    @(negedge clk);
    addr = a; sel_n = 0; sel = 1; wr_n = 1; oe_n = 0; lane_n = ln; tb_en = ln;
    tb_val = 16'h0000;
    #1 chk(req, bus, exp);
    idle();
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    rd("R7 reset addr0", 0, 2'b00, 16'h0000);
    rd("R7 reset top", AW'(1023), 2'b00, 16'h0000);
    @(negedge clk) #1 chk("R6 idle standby", {15'b0, standby}, 16'h1);
  endtask

  task automatic t_lanes();
    wr(3, 16'hA1B2, 2'b00);
    rd("R4 both lanes", 3, 2'b00, 16'hA1B2);
    wr(3, 16'h77C4, 2'b10);
    rd("R3 low lane write", 3, 2'b00, 16'hA1C4);
    wr(3, 16'h3E99, 2'b01);
    rd("R3 high lane write", 3, 2'b00, 16'h3EC4);
    wr(3, 16'hFFFF, 2'b11);
    rd("R3 no lane write", 3, 2'b00, 16'h3EC4);
    rd("R4 low lane only", 3, 2'b10, 16'h00C4);
    rd("R4 high lane only", 3, 2'b01, 16'h3E00);
  endtask

  task automatic t_select();
    wr(7, 16'h1234, 2'b00, 1, 1);
    rd("R1 write blocked sel_n high", 7, 2'b00, 16'h0000);
    wr(7, 16'h1234, 2'b00, 0, 0);
    rd("R1 write blocked sel low", 7, 2'b00, 16'h0000);
    wr(8, 16'hC0DE, 2'b00, 0, 1, 0);
    rd("R2 write with oe low", 8, 2'b00, 16'hC0DE);
  endtask

  task automatic t_address();
    wr(0, 16'h1111, 2'b00);
    wr(AW'(1023), 16'hBEEF, 2'b00);
    wr(1, 16'h2222, 2'b00);
    rd("R8 lowest addr", 0, 2'b00, 16'h1111);
    rd("R8 highest addr", AW'(1023), 2'b00, 16'hBEEF);
    rd("R8 neighbour addr", 1, 2'b00, 16'h2222);
  endtask

  task automatic t_truth();
    logic [15:0] stored = 16'h5AA5;
    wr(5, stored, 2'b00);
    for (int c = 0; c < 64; c++) begin
      logic s_n, s, w_n, o_n, is_sel, is_wr, is_rd, exp_sb;
      logic [1:0] l_n, drv;
      logic [15:0] exp;
      {s_n, s, w_n, o_n, l_n} = 6'(c);
      is_sel = !s_n && s;
      is_wr  = is_sel && !w_n;
      is_rd  = is_sel && !o_n && w_n;
      drv    = is_rd ? ~l_n : 2'b00;
      exp_sb = !is_sel || (&l_n);
      @(negedge clk);
      addr = 5; sel_n = s_n; sel = s; wr_n = w_n; oe_n = o_n; lane_n = l_n;
      tb_en  = ~drv;
      tb_val = is_wr ? stored : 16'h0000;
      exp[7:0]  = drv[0] ? stored[7:0]  : tb_val[7:0];
      exp[15:8] = drv[1] ? stored[15:8] : tb_val[15:8];
      #1;
      chk($sformatf("R4 R5 bus combo %0d", c), bus, exp);
      chk($sformatf("R6 standby combo %0d", c), {15'b0, standby}, {15'b0, exp_sb});
    end
    idle();
    rd("R2 truth sweep kept word", 5, 2'b00, stored);
  endtask

  initial begin
    t_reset();
    t_lanes();
    t_select();
    t_address();
    t_truth();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule